// File: doc/BRIEF.md
# PCI Target Data-Phase Controller

This block is the bus-cycle sequencer for the target side of a 32-bit PCI interface. On every rising edge of the bus clock it samples the cycle-frame and initiator-ready strobes together with the multiplexed address/data lines and the command/byte-enable lines. When an address phase carries a memory read or memory write aimed at one of its decoded windows, it claims the cycle with its device-select output one clock later. It then paces the data phases with its target-ready output and ends bursts that reach a programmable length with a disconnect that still carries data.

Each completed data phase is handed to a simple local port as a one-clock read or write strobe. The strobe comes with the current word address, the write data and the byte enables. Read data comes back on the same clock, with no wait states. A one-clock done pulse marks the turnaround cycle that closes every claimed transaction. The three target control outputs and the data lines each have an output-enable signal for the pad ring. These enables switch off at once when the bus reset is asserted, and they are switched on only for a claimed cycle.

Top module: `pci_tgt_phase_ctrl`

## Requirements
- R1: While `rst_n` is low, every output enable (`sel_oe_o`, `tgt_rdy_oe_o`, `halt_oe_o`, `bus_ad_oe_o`) is 0 and `loc_done_o` is 0. The enables drop as soon as reset is asserted, without waiting for a clock edge.
- R2: An address phase is claimed only if its command value on `bus_cbe_n_i` is 4'b0110 (memory read) or 4'b0111 (memory write). Any other command leaves every enable at 0 and raises no local strobe.
- R3: For a claimed cycle, in the clock after the address phase, `sel_n_o` is 0 with its enable on and `tgt_rdy_n_o` is 1 with its enable on. `tgt_rdy_n_o` goes to 0 one clock later.
- R4: A data phase completes, and raises exactly one of `loc_wr_o`/`loc_rd_o`, only on a clock where `init_rdy_n_i` and `tgt_rdy_n_o` are both 0. Initiator wait states raise no strobe and leave the address unchanged.
- R5: On a write phase, `loc_wdata_o` equals `bus_ad_i` and `loc_be_o` equals the inverse of `bus_cbe_n_i`.
- R6: During the data phases of a read, `bus_ad_oe_o` is 1 and `bus_ad_o` equals `loc_rdata_i`.
- R7: The clock after the final phase is the turnaround clock. In it, `sel_n_o`, `tgt_rdy_n_o` and `halt_n_o` are 1 with their enables on, and `loc_done_o` is 1. On the next clock all enables are 0. A phase is final when `cyc_n_i` is already 1 as the phase completes.
- R8: With `limit_i` = N > 0, data phase N (1-based) shows `halt_n_o` = 0 together with `tgt_rdy_n_o` = 0. If `cyc_n_i` is still 0 when that phase completes, `tgt_rdy_n_o` returns to 1 while `halt_n_o` stays 0 until `cyc_n_i` is 1, and then turnaround follows. At most N phases transfer. `limit_i` = 0 sets no limit.
- R9: An address outside every window is not claimed. While such a foreign transaction is in progress, nothing is claimed, even an address/command that would hit. The block watches for a new address phase only after a clock with `cyc_n_i` and `init_rdy_n_i` both 1.
- R10: `loc_addr_o` equals the start address for the first phase and increases by 4 after each completed phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus reset, active low, asynchronous assert |
| cyc_n_i | input | 1 | Cycle frame from initiator, active low |
| init_rdy_n_i | input | 1 | Initiator ready, active low |
| bus_ad_i | input | 32 | Address/data lines as sampled |
| bus_cbe_n_i | input | 4 | Command (address phase) / byte enables, active low (data phase) |
| limit_i | input | BURST_W | Maximum data phases per transaction, 0 = unlimited |
| sel_n_o | output | 1 | Device-select drive value, active low |
| sel_oe_o | output | 1 | Output enable for device select |
| tgt_rdy_n_o | output | 1 | Target-ready drive value, active low |
| tgt_rdy_oe_o | output | 1 | Output enable for target ready |
| halt_n_o | output | 1 | Stop-request drive value, active low |
| halt_oe_o | output | 1 | Output enable for the stop request |
| bus_ad_o | output | 32 | Read data driven onto the address/data lines |
| bus_ad_oe_o | output | 1 | Output enable for the address/data lines |
| loc_addr_o | output | 32 | Current phase byte address |
| loc_wr_o | output | 1 | Write strobe, one per completed write phase |
| loc_rd_o | output | 1 | Read strobe, one per completed read phase |
| loc_wdata_o | output | 32 | Write data |
| loc_be_o | output | 4 | Byte enables, active high |
| loc_rdata_i | input | 32 | Read data for `loc_addr_o`, same clock |
| loc_done_o | output | 1 | One-clock pulse in the turnaround clock |

## Verification
The bench builds the block with two 256-byte windows and a 3-bit burst limit. This makes it cheap to sweep every one of the 16 command codes against both windows and a missing address. It also allows every pairing of burst length 1 to 5 with limits 0 to 4, so the block is exercised where the limit is below, equal to and above the length the initiator wants. Each of those bursts runs for reads and for writes, with and without initiator wait states. This reaches both ways a limited burst can end: straight into turnaround when the limit phase is also final, and through the stop-wait clock when the initiator still holds the frame. Separate cases cover a foreign transaction that shows a hitting address mid-cycle, and a reset asserted in the middle of a data phase.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,   // bus watched for an address phase
      ST_BUSY  = 3'd1,   // foreign transaction in progress
      ST_CLAIM = 3'd2,   // select driven, ready held off
      ST_DATA  = 3'd3,   // ready driven, phases complete here
      ST_STOPW = 3'd4,   // stop held, waiting for the frame to drop
      ST_TURN  = 3'd5    // all controls driven high for one clock
   } tgt_state_e;

   localparam logic [3:0] CMD_MEM_RD = 4'b0110;
   localparam logic [3:0] CMD_MEM_WR = 4'b0111;
   localparam logic [31:0] WORD_STEP = 32'd4;

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
   import pci_tgt_pkg::*;
#(
   parameter int NUM_WIN = 2,
   parameter int WIN_BITS = 12,
   parameter logic [NUM_WIN*32-1:0] WIN_BASE = '0,
   localparam int TAG_W = 32 - WIN_BITS
) (
   input  logic [TAG_W-1:0] addr_tag_i,
   input  logic [3:0]       cmd_i,
   output logic             hit_o,
   output logic             is_wr_o
);

   logic [NUM_WIN-1:0] win_match;
   logic               cmd_ok;

   // One comparator per window, all in parallel.
   generate
      for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
         assign win_match[g] = (addr_tag_i == WIN_BASE[g*32+WIN_BITS +: TAG_W]);
      end
   endgenerate

   assign cmd_ok  = (cmd_i == CMD_MEM_RD) || (cmd_i == CMD_MEM_WR);
   assign hit_o   = cmd_ok && (|win_match);
   assign is_wr_o = (cmd_i == CMD_MEM_WR);

endmodule

// File: rtl/pci_tgt_burst.sv
module pci_tgt_burst
   import pci_tgt_pkg::*;
#(
   parameter int BURST_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [31:0]        start_addr_i,
   input  logic               advance_i,
   input  logic [BURST_W-1:0] limit_i,
   output logic [31:0]        addr_o,
   output logic               at_limit_o
);

   logic [31:0]        addr_q;
   logic [BURST_W-1:0] beats_q;   // phases completed so far

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         beats_q <= '0;
      end else if (load_i) begin
         addr_q  <= start_addr_i;
         beats_q <= '0;
      end else if (advance_i) begin
         addr_q  <= addr_q + WORD_STEP;
         beats_q <= beats_q + 1'b1;
      end
   end

   // The phase now on the bus is the last one the limit allows.
   assign at_limit_o = (limit_i != '0) && (beats_q == (limit_i - 1'b1));
   assign addr_o     = addr_q;

endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
   import pci_tgt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cyc_n_i,
   input  logic       init_rdy_n_i,
   input  logic       hit_i,
   input  logic       is_wr_i,
   input  logic       at_limit_i,
   output tgt_state_e state_o,
   output logic       wr_o,
   output logic       load_o,
   output logic       advance_o
);

   tgt_state_e state_q, state_d;
   logic       wr_q;

   assign load_o    = (state_q == ST_IDLE) && !cyc_n_i && hit_i;
   assign advance_o = (state_q == ST_DATA) && !init_rdy_n_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (!cyc_n_i) state_d = hit_i ? ST_CLAIM : ST_BUSY;
         end
         ST_BUSY: begin
            if (cyc_n_i && init_rdy_n_i) state_d = ST_IDLE;
         end
         ST_CLAIM: state_d = ST_DATA;
         ST_DATA: begin
            if (!init_rdy_n_i) begin
               if (cyc_n_i)         state_d = ST_TURN;
               else if (at_limit_i) state_d = ST_STOPW;
            end else if (cyc_n_i) begin
               state_d = ST_TURN;   // initiator gave up the cycle
            end
         end
         ST_STOPW: begin
            if (cyc_n_i) state_d = ST_TURN;
         end
         ST_TURN: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (load_o) wr_q <= is_wr_i;
      end
   end

   assign state_o = state_q;
   assign wr_o    = wr_q;

endmodule

// File: rtl/pci_tgt_phase_ctrl.sv
module pci_tgt_phase_ctrl
   import pci_tgt_pkg::*;
#(
   parameter int NUM_WIN = 2,
   parameter int WIN_BITS = 12,
   parameter logic [NUM_WIN*32-1:0] WIN_BASE = {32'hC000_0000, 32'h8000_0000},
   parameter int BURST_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cyc_n_i,
   input  logic               init_rdy_n_i,
   input  logic [31:0]        bus_ad_i,
   input  logic [3:0]         bus_cbe_n_i,
   input  logic [BURST_W-1:0] limit_i,
   output logic               sel_n_o,
   output logic               sel_oe_o,
   output logic               tgt_rdy_n_o,
   output logic               tgt_rdy_oe_o,
   output logic               halt_n_o,
   output logic               halt_oe_o,
   output logic [31:0]        bus_ad_o,
   output logic               bus_ad_oe_o,
   output logic [31:0]        loc_addr_o,
   output logic               loc_wr_o,
   output logic               loc_rd_o,
   output logic [31:0]        loc_wdata_o,
   output logic [3:0]         loc_be_o,
   input  logic [31:0]        loc_rdata_i,
   output logic               loc_done_o
);

   generate
      if (NUM_WIN < 1)                  begin : g_bad_win   $error("NUM_WIN must be at least 1"); end
      if (WIN_BITS < 2 || WIN_BITS > 31) begin : g_bad_bits  $error("WIN_BITS must be 2..31"); end
      if (BURST_W < 1 || BURST_W > 16)   begin : g_bad_burst $error("BURST_W must be 1..16"); end
   endgenerate

   tgt_state_e state;
   logic       hit, is_wr, wr_q, load, advance, at_limit;
   logic       drive, claimed;

   pci_tgt_decode #(
      .NUM_WIN (NUM_WIN),
      .WIN_BITS(WIN_BITS),
      .WIN_BASE(WIN_BASE)
   ) u_decode (
      .addr_tag_i(bus_ad_i[31:WIN_BITS]),
      .cmd_i     (bus_cbe_n_i),
      .hit_o     (hit),
      .is_wr_o   (is_wr)
   );

   pci_tgt_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .cyc_n_i     (cyc_n_i),
      .init_rdy_n_i(init_rdy_n_i),
      .hit_i       (hit),
      .is_wr_i     (is_wr),
      .at_limit_i  (at_limit),
      .state_o     (state),
      .wr_o        (wr_q),
      .load_o      (load),
      .advance_o   (advance)
   );

   pci_tgt_burst #(
      .BURST_W(BURST_W)
   ) u_burst (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load),
      .start_addr_i(bus_ad_i),
      .advance_i   (advance),
      .limit_i     (limit_i),
      .addr_o      (loc_addr_o),
      .at_limit_o  (at_limit)
   );

   // Bus controls decode from registered state only, so they carry
   // no path from the sampled bus inputs.
   always_comb begin
      claimed      = (state == ST_CLAIM) || (state == ST_DATA) || (state == ST_STOPW);
      drive        = claimed || (state == ST_TURN);
      sel_oe_o     = drive;
      tgt_rdy_oe_o = drive;
      halt_oe_o    = drive;
      sel_n_o      = !claimed;
      tgt_rdy_n_o  = !(state == ST_DATA);
      halt_n_o     = !(((state == ST_DATA) && at_limit) || (state == ST_STOPW));
      bus_ad_oe_o  = !wr_q && ((state == ST_DATA) || (state == ST_STOPW));
      loc_done_o   = (state == ST_TURN);
   end

   assign bus_ad_o    = loc_rdata_i;
   assign loc_wr_o    = advance && wr_q;
   assign loc_rd_o    = advance && !wr_q;
   assign loc_wdata_o = bus_ad_i;
   assign loc_be_o    = ~bus_cbe_n_i;

endmodule

// File: rtl/pci_tgt_phase_ctrl_chk.sv
module pci_tgt_phase_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic cyc_n_i,
   input logic init_rdy_n_i,
   input logic sel_n_o,
   input logic sel_oe_o,
   input logic tgt_rdy_n_o,
   input logic tgt_rdy_oe_o,
   input logic halt_n_o,
   input logic halt_oe_o,
   input logic bus_ad_oe_o,
   input logic loc_wr_o,
   input logic loc_rd_o,
   input logic loc_done_o
);

   // R1: a clock seen in reset leaves all enables off at the next clock
   a_r1_reset_released: assert property (@(posedge clk)
      !rst_n |=> !sel_oe_o && !tgt_rdy_oe_o && !halt_oe_o && !bus_ad_oe_o && !loc_done_o);

   // R3: the first driven clock shows select asserted, ready not yet
   a_r3_select_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_oe_o) |-> !sel_n_o && tgt_rdy_n_o);

   // R3: ready only asserts after a clock of select
   a_r3_ready_after_select: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tgt_rdy_n_o) |-> $past(sel_oe_o && !sel_n_o));

   // R4: a local strobe means both ready signals are low
   a_r4_strobe_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_wr_o || loc_rd_o) |-> !init_rdy_n_i && !tgt_rdy_n_o && tgt_rdy_oe_o);

   // R4: never both strobes
   a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({loc_wr_o, loc_rd_o}));

   // R7: turnaround drives all controls high, then releases them
   a_r7_turn_high: assert property (@(posedge clk) disable iff (!rst_n)
      loc_done_o |-> sel_oe_o && sel_n_o && tgt_rdy_n_o && halt_n_o && halt_oe_o);

   a_r7_turn_release: assert property (@(posedge clk) disable iff (!rst_n)
      loc_done_o |=> !sel_oe_o && !tgt_rdy_oe_o && !halt_oe_o && !bus_ad_oe_o);

   // R8: disconnect with data and frame still held -> stop kept, ready dropped
   a_r8_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_oe_o && !halt_n_o && !tgt_rdy_n_o && !init_rdy_n_i && !cyc_n_i)
      |=> tgt_rdy_n_o && !halt_n_o && halt_oe_o);

endmodule

bind pci_tgt_phase_ctrl pci_tgt_phase_ctrl_chk chk_i (.*);

// File: tb/pci_tgt_phase_ctrl_tb.sv
module pci_tgt_phase_ctrl_tb_top;

   localparam int NW = 2;
   localparam int WB = 8;
   localparam int BW = 3;
   localparam logic [NW*32-1:0] BASES = {32'h2000_0100, 32'h1000_0000};
   localparam logic [31:0] RKEY = 32'h5A5A_0000;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cyc_n_i, init_rdy_n_i;
   logic [31:0]   bus_ad_i;
   logic [3:0]    bus_cbe_n_i;
   logic [BW-1:0] limit_i;
   logic          sel_n_o, sel_oe_o, tgt_rdy_n_o, tgt_rdy_oe_o, halt_n_o, halt_oe_o;
   logic [31:0]   bus_ad_o;
   logic          bus_ad_oe_o;
   logic [31:0]   loc_addr_o, loc_wdata_o, loc_rdata_i;
   logic          loc_wr_o, loc_rd_o, loc_done_o;
   logic [3:0]    loc_be_o;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   assign loc_rdata_i = loc_addr_o ^ RKEY;

   pci_tgt_phase_ctrl #(
      .NUM_WIN(NW), .WIN_BITS(WB), .WIN_BASE(BASES), .BURST_W(BW)
   ) dut_i (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_released(input string req);
      chk(req, {28'd0, sel_oe_o, tgt_rdy_oe_o, halt_oe_o, bus_ad_oe_o}, 32'd0);
      chk(req, {30'd0, loc_wr_o, loc_rd_o}, 32'd0);
   endtask

   // Address phase that must not be claimed (R2, R9).
   task automatic run_miss(input logic [31:0] a, input logic [3:0] cmd, input string req);
      cyc_n_i = 1'b0; init_rdy_n_i = 1'b1; bus_ad_i = a; bus_cbe_n_i = cmd;
      step();
      cyc_n_i = 1'b1; init_rdy_n_i = 1'b0; bus_ad_i = 32'hFFFF_0000; bus_cbe_n_i = 4'h0;
      #1 chk_released(req);
      step();
      init_rdy_n_i = 1'b1;
      #1 chk_released(req);
      step();
      chk_released(req);
   endtask

   // Claimed burst with a bench-side model of every clock.
   task automatic run_burst(input logic [31:0] a, input bit wr, input int n,
                            input int lim, input logic [7:0] wpat);
      int  b = 0;
      int  cyc = 0;
      bit  first = 1'b1;
      bit  stopw = 1'b0;
      bit  done = 1'b0;
      int  exp_beats;
      limit_i = lim[BW-1:0];
      cyc_n_i = 1'b0; init_rdy_n_i = 1'b1; bus_ad_i = a;
      bus_cbe_n_i = wr ? 4'b0111 : 4'b0110;
      step();
      chk("R3 select one clock after address", {30'd0, sel_oe_o, sel_n_o}, 32'd2);
      chk("R3 ready held off in claim clock", {30'd0, tgt_rdy_oe_o, tgt_rdy_n_o}, 32'd3);
      while (!done) begin
         bit tr_exp = !first && !stopw;
         bit st_exp = stopw || (tr_exp && lim != 0 && b == lim - 1);
         bit w = wpat[cyc % 8];
         bit xfer_exp;
         if (first) begin
            init_rdy_n_i = 1'b1; cyc_n_i = 1'b0;
         end else if (stopw) begin
            init_rdy_n_i = 1'b0; cyc_n_i = 1'b1;
         end else begin
            init_rdy_n_i = w; cyc_n_i = (!w && b == n - 1);
         end
         if (wr) begin
            bus_ad_i    = 32'hC0DE_0000 + 32'(b * 17 + cyc);
            bus_cbe_n_i = 4'(b) ^ 4'h5;
         end else begin
            bus_ad_i    = 32'h0;
            bus_cbe_n_i = 4'h0;
         end
         xfer_exp = tr_exp && !init_rdy_n_i;
         #1;
         chk("R4 ready timing", {31'd0, tgt_rdy_n_o}, {31'd0, !tr_exp});
         chk("R8 stop timing", {31'd0, halt_n_o}, {31'd0, !st_exp});
         chk("R4 write strobe", {31'd0, loc_wr_o}, {31'd0, xfer_exp && wr});
         chk("R4 read strobe", {31'd0, loc_rd_o}, {31'd0, xfer_exp && !wr});
         if (tr_exp) chk("R10 linear address", loc_addr_o, a + 32'(4 * b));
         if (xfer_exp && wr) begin
            chk("R5 write data", loc_wdata_o, bus_ad_i);
            chk("R5 byte enables", {28'd0, loc_be_o}, {28'd0, ~bus_cbe_n_i});
         end
         if (tr_exp && !wr) begin
            chk("R6 read drive enable", {31'd0, bus_ad_oe_o}, 32'd1);
            chk("R6 read data", bus_ad_o, (a + 32'(4 * b)) ^ RKEY);
         end
         step();
         if (stopw) begin
            done = 1'b1;
         end else if (xfer_exp) begin
            b++;
            if (cyc_n_i) done = 1'b1;
            else if (st_exp) stopw = 1'b1;
         end
         first = 1'b0;
         cyc++;
      end
      cyc_n_i = 1'b1; init_rdy_n_i = 1'b1;
      #1;
      chk("R7 turnaround done pulse", {31'd0, loc_done_o}, 32'd1);
      chk("R7 turnaround drives high",
          {26'd0, sel_oe_o, sel_n_o, tgt_rdy_oe_o, tgt_rdy_n_o, halt_oe_o, halt_n_o}, 32'h3F);
      exp_beats = (lim != 0 && lim < n) ? lim : n;
      chk("R8 phases transferred", 32'(b), 32'(exp_beats));
      step();
      chk_released("R7 released after turnaround");
      chk("R7 done is one clock", {31'd0, loc_done_o}, 32'd0);
   endtask

   initial begin
      #1_500_000;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] addr;
      rst_n = 1'b0; cyc_n_i = 1'b1; init_rdy_n_i = 1'b1;
      bus_ad_i = '0; bus_cbe_n_i = 4'hF; limit_i = '0;
      repeat (3) @(negedge clk);
      chk_released("R1 reset state");
      chk("R1 no done in reset", {31'd0, loc_done_o}, 32'd0);
      rst_n = 1'b1;
      step();
      chk_released("R1 idle after reset");

      // Command x window sweep (R2, R9).
      for (int w = 0; w < 3; w++) begin
         for (int c = 0; c < 16; c++) begin
            addr = (w == 0) ? 32'h1000_0040 : (w == 1) ? 32'h2000_01FC : 32'h1000_0140;
            if (w < 2 && (c == 6 || c == 7))
               run_burst(addr, c == 7, 1, 0, 8'h00);
            else
               run_miss(addr, 4'(c), (w < 2) ? "R2 command not claimed" : "R9 address outside windows");
         end
      end

      // Burst length x limit sweep (R3..R8, R10).
      for (int wr = 0; wr < 2; wr++)
         for (int n = 1; n <= 5; n++)
            for (int lim = 0; lim <= 4; lim++)
               for (int wp = 0; wp < 2; wp++)
                  run_burst(((n + lim) % 2 == 0) ? 32'h1000_0010 : 32'h2000_0120,
                            wr[0], n, lim, (wp == 0) ? 8'h00 : 8'b0101_0010);

      // Foreign transaction showing a hit mid-cycle (R9).
      cyc_n_i = 1'b0; init_rdy_n_i = 1'b1; bus_ad_i = 32'h3000_0000; bus_cbe_n_i = 4'b0111;
      step();
      init_rdy_n_i = 1'b0; bus_ad_i = 32'h1000_0000; bus_cbe_n_i = 4'b0111;
      #1 chk_released("R9 busy ignores hit");
      step();
      chk_released("R9 busy ignores hit");
      cyc_n_i = 1'b1;
      step();
      init_rdy_n_i = 1'b1;
      #1 chk_released("R9 busy ignores hit");
      step();
      run_burst(32'h1000_0080, 1'b1, 2, 0, 8'h00);

      // Reset asserted mid data phase (R1).
      limit_i = '0;
      cyc_n_i = 1'b0; init_rdy_n_i = 1'b1; bus_ad_i = 32'h1000_0000; bus_cbe_n_i = 4'b0110;
      step();
      step();
      chk("R1 driving before reset", {31'd0, tgt_rdy_oe_o}, 32'd1);
      #2 rst_n = 1'b0;
      #1 chk_released("R1 release at reset edge");
      step();
      rst_n = 1'b1; cyc_n_i = 1'b1; init_rdy_n_i = 1'b1;
      step();
      chk_released("R1 idle after mid reset");
      run_burst(32'h2000_0100, 1'b0, 3, 2, 8'h00);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule